// File: doc/BRIEF.md
# Timer Output Compare Unit

This block watches a free-running 16-bit timer and a programmed 16-bit compare value and acts when the two become equal. The action depends on a 4-bit mode code: the output pin can be driven high or driven low, the pin can be left alone while only a match flag is raised, or the match can issue a special event that pulses a timer-reset request. In the special event case, the ADC-linked build of the block also pulses an ADC-start request, but only while the ADC enable input is high.

Equality is evaluated every clock, but a match is acted on only in the first cycle of equality. A timer that stalls on the compare value therefore does not re-trigger the block. When the set or clear mode is selected, the pin is first forced to the opposite level, so the later match shows up as a clean edge. The timer and the converter are external. The pin is assumed to be wired as an output, and the timer is assumed to run synchronously to this clock.

Top module: `outcmp_unit`

## Requirements
- R1: During and after a synchronous reset, pin_out, match_flag, tmr_clr and adc_go are all 0.
- R2: With mode 4'b1000 (set), the first cycle in which tmr_val equals cmp_val makes pin_out 1 and match_flag 1 after the next rising clock edge.
- R3: With mode 4'b1001 (clear), the first cycle of equality makes pin_out 0 and match_flag 1 after the next rising clock edge.
- R4: With mode 4'b1010 (flag only), a match raises match_flag for one cycle and leaves pin_out unchanged.
- R5: A match is acted on once. While equality persists, no further match_flag, pin change, tmr_clr or adc_go occurs. A new action needs at least one cycle of inequality first.
- R6: With mode 4'b1011 (special event), a match gives a one-cycle tmr_clr pulse and a one-cycle match_flag, and leaves pin_out unchanged.
- R7: adc_go pulses together with tmr_clr only when ADC_LINK is 1 and adc_en is 1 in the matching cycle. Otherwise adc_go stays 0.
- R8: When the mode code changes to 4'b1000, pin_out is forced to 0 after the next edge. When it changes to 4'b1001, pin_out is forced to 1 after the next edge. If a match occurs in that same cycle, the match level wins.
- R9: Mode codes whose top two bits are not 2'b10 perform no action: pin_out holds, and match_flag, tmr_clr and adc_go stay 0.
- R10: A match needs all 16 bits to be equal. A timer value that agrees only in the high byte, or only in the low byte, does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_val | input | 16 | Running timer value |
| cmp_val | input | 16 | Programmed compare value |
| mode | input | 4 | Compare mode code |
| adc_en | input | 1 | ADC enabled, qualifies the ADC start |
| pin_out | output | 1 | Compare output pin level |
| tmr_clr | output | 1 | One-cycle timer reset request |
| adc_go | output | 1 | One-cycle ADC start request |
| match_flag | output | 1 | One-cycle match indication |

## Verification
A corrupted equality history register would show up at the ports within one cycle, either as a repeated match_flag while the timer rests on the compare value or as a missed first match. A stale registered mode would show up on the edge after a mode change: the pin would not be forced to the opposite level, or the wrong action would be taken. The pin level is itself state, so an action decoded wrongly stays visible on pin_out until the next match or mode entry. Each scenario therefore samples the pin one edge after each stimulus.

// File: rtl/outcmp_pkg.sv
package outcmp_pkg;

    localparam int OC_MODE_W = 4;

    typedef logic [OC_MODE_W-1:0] oc_mode_t;

    localparam oc_mode_t OC_SET  = 4'b1000;
    localparam oc_mode_t OC_CLR  = 4'b1001;
    localparam oc_mode_t OC_FLAG = 4'b1010;
    localparam oc_mode_t OC_SEV  = 4'b1011;

    // Decoded action for one mode code
    typedef struct packed {
        logic active;   // a compare mode at all
        logic go_hi;    // drive pin high on match
        logic go_lo;    // drive pin low on match
        logic sev;      // special event on match
    } oc_act_t;

    function automatic oc_act_t oc_decode(oc_mode_t m);
        oc_act_t a;
        a.active = (m[3:2] == 2'b10);
        a.go_hi  = (m == OC_SET);
        a.go_lo  = (m == OC_CLR);
        a.sev    = (m == OC_SEV);
        return a;
    endfunction

endpackage

// File: rtl/outcmp_match.sv
module outcmp_match #(
    parameter int TW     = 16,
    parameter int LANE_W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] tmr_val,
    input  logic [TW-1:0] cmp_val,
    output logic          first_eq
);
    localparam int LANES = TW / LANE_W;

    logic [LANES-1:0] lane_eq;
    logic             eq_all;
    logic             eq_q;

    // Per-byte comparison, then combine
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (tmr_val[g*LANE_W +: LANE_W] == cmp_val[g*LANE_W +: LANE_W]);
    end

    assign eq_all   = &lane_eq;
    assign first_eq = eq_all & ~eq_q;

    always_ff @(posedge clk) begin
        if (rst) eq_q <= 1'b0;
        else     eq_q <= eq_all;
    end

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        first_eq |=> !first_eq); // R5

endmodule

// File: rtl/outcmp_mode.sv
module outcmp_mode
    import outcmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  oc_mode_t mode,
    output oc_act_t  act,
    output logic     force_lo,
    output logic     force_hi
);
    oc_mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode;
    end

    assign act      = oc_decode(mode);
    assign force_lo = (mode == OC_SET) && (mode_q != OC_SET);
    assign force_hi = (mode == OC_CLR) && (mode_q != OC_CLR);

    AST_FORCE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(force_lo && force_hi)); // R8

endmodule

// File: rtl/outcmp_act.sv
module outcmp_act
    import outcmp_pkg::*;
#(
    parameter bit ADC_LINK = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    first_eq,
    input  oc_act_t act,
    input  logic    force_lo,
    input  logic    force_hi,
    input  logic    adc_en,
    output logic    pin_out,
    output logic    tmr_clr,
    output logic    adc_go,
    output logic    match_flag
);
    logic hit;
    logic pin_nxt;
    logic go_nxt;

    assign hit = first_eq & act.active;

    always_comb begin
        pin_nxt = pin_out;
        if (hit && act.go_hi)      pin_nxt = 1'b1;
        else if (hit && act.go_lo) pin_nxt = 1'b0;
        else if (force_lo)         pin_nxt = 1'b0;
        else if (force_hi)         pin_nxt = 1'b1;
    end

    if (ADC_LINK) begin : g_adc
        assign go_nxt = hit & act.sev & adc_en;
    end else begin : g_no_adc
        assign go_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_out    <= 1'b0;
            tmr_clr    <= 1'b0;
            adc_go     <= 1'b0;
            match_flag <= 1'b0;
        end else begin
            pin_out    <= pin_nxt;
            tmr_clr    <= hit & act.sev;
            adc_go     <= go_nxt;
            match_flag <= hit;
        end
    end

    AST_SET_HIGH: assert property (@(posedge clk) disable iff (rst)
        (hit && act.go_hi) |=> pin_out); // R2
    AST_CLR_LOW: assert property (@(posedge clk) disable iff (rst)
        (hit && act.go_lo) |=> !pin_out); // R3
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hit && !act.go_hi && !act.go_lo && !force_lo && !force_hi) |=> $stable(pin_out)); // R4
    AST_FLAG_PULSE: assert property (@(posedge clk) disable iff (rst)
        match_flag |=> !match_flag); // R5
    AST_SEV_CLR: assert property (@(posedge clk) disable iff (rst)
        tmr_clr |-> match_flag); // R6
    AST_ADC_QUAL: assert property (@(posedge clk) disable iff (rst)
        adc_go |-> (tmr_clr && $past(adc_en))); // R7
    AST_IDLE_MODE: assert property (@(posedge clk) disable iff (rst)
        (!act.active && !force_lo && !force_hi) |=> ($stable(pin_out) && !match_flag)); // R9

endmodule

// File: rtl/outcmp_unit.sv
module outcmp_unit
    import outcmp_pkg::*;
#(
    parameter int TW       = 16,
    parameter int LANE_W   = 8,
    parameter bit ADC_LINK = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TW-1:0]        tmr_val,
    input  logic [TW-1:0]        cmp_val,
    input  logic [OC_MODE_W-1:0] mode,
    input  logic                 adc_en,
    output logic                 pin_out,
    output logic                 tmr_clr,
    output logic                 adc_go,
    output logic                 match_flag
);
    logic    first_eq;
    oc_act_t act;
    logic    force_lo;
    logic    force_hi;

    outcmp_match #(.TW(TW), .LANE_W(LANE_W)) u_match (
        .clk      (clk),
        .rst      (rst),
        .tmr_val  (tmr_val),
        .cmp_val  (cmp_val),
        .first_eq (first_eq)
    );

    outcmp_mode u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .act      (act),
        .force_lo (force_lo),
        .force_hi (force_hi)
    );

    outcmp_act #(.ADC_LINK(ADC_LINK)) u_act (
        .clk        (clk),
        .rst        (rst),
        .first_eq   (first_eq),
        .act        (act),
        .force_lo   (force_lo),
        .force_hi   (force_hi),
        .adc_en     (adc_en),
        .pin_out    (pin_out),
        .tmr_clr    (tmr_clr),
        .adc_go     (adc_go),
        .match_flag (match_flag)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!pin_out && !tmr_clr && !adc_go && !match_flag)); // R1

endmodule

// File: tb/outcmp_unit_tb.sv
`timescale 1ns/1ps
module outcmp_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tmr_val = 16'h0000;
    logic [15:0] cmp_val = 16'h0001;
    logic [3:0]  mode = 4'b0000;
    logic        adc_en = 1'b0;
    logic        pin_out, tmr_clr, adc_go, match_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    outcmp_unit dut_i (
        .clk(clk), .rst(rst), .tmr_val(tmr_val), .cmp_val(cmp_val),
        .mode(mode), .adc_en(adc_en), .pin_out(pin_out), .tmr_clr(tmr_clr),
        .adc_go(adc_go), .match_flag(match_flag)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // outputs packed as {pin, flag, clr, go}
    function automatic logic [3:0] outs();
        return {pin_out, match_flag, tmr_clr, adc_go};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        chk("R1 reset", outs(), 4'b0000);
        rst = 1'b0;
        step();
        chk("R1 after reset", outs(), 4'b0000);
    endtask

    task automatic t_set();
        mode = 4'b1000; cmp_val = 16'h1234; tmr_val = 16'h1230;
        step();
        chk("R8 set entry", outs(), 4'b0000);
        tmr_val = 16'h1234;
        step();
        chk("R2 set match", outs(), 4'b1100);
        step();
        chk("R5 persist no refire", outs(), 4'b1000);
    endtask

    task automatic t_flag();
        mode = 4'b1010; tmr_val = 16'h0000;
        step();
        tmr_val = 16'h1234;
        step();
        chk("R4 flag only", outs(), 4'b1100);
        step();
        chk("R4 flag pulse ends", outs(), 4'b1000);
    endtask

    task automatic t_reentry();
        mode = 4'b1000; tmr_val = 16'h0000;
        step();
        chk("R8 set entry forces low", outs(), 4'b0000);
        tmr_val = 16'h1234;
        step();
        chk("R2 set match again", outs(), 4'b1100);
        mode = 4'b1001; tmr_val = 16'h0000;
        step();
        chk("R8 clear entry", outs(), 4'b1000);
        tmr_val = 16'h1234;
        step();
        chk("R3 clear match", outs(), 4'b0100);
        mode = 4'b1010; tmr_val = 16'h0000;
        step();
        mode = 4'b1001;
        step();
        chk("R8 clear entry forces high", outs(), 4'b1000);
        // entry and match together: match level wins
        mode = 4'b1000; tmr_val = 16'h1234;
        step();
        chk("R8 match wins over entry", outs(), 4'b1100);
    endtask

    task automatic t_refire();
        mode = 4'b1010;
        tmr_val = 16'h1234;
        step(); step(); step();
        chk("R5 held equality quiet", outs(), 4'b1000);
        tmr_val = 16'h1235;
        step();
        tmr_val = 16'h1234;
        step();
        chk("R5 refire after inequality", outs(), 4'b1100);
    endtask

    task automatic t_sev();
        mode = 4'b1011; adc_en = 1'b1; tmr_val = 16'h0000;
        step();
        tmr_val = 16'h1234;
        step();
        chk("R6 R7 event with adc", outs(), 4'b1111);
        step();
        chk("R6 event pulse ends", outs(), 4'b1000);
        adc_en = 1'b0; tmr_val = 16'h0000;
        step();
        tmr_val = 16'h1234;
        step();
        chk("R7 adc disabled", outs(), 4'b1110);
    endtask

    task automatic t_other();
        mode = 4'b0000; tmr_val = 16'h0000;
        step();
        tmr_val = 16'h1234;
        step();
        chk("R9 mode 0000 idle", outs(), 4'b1000);
        mode = 4'b1100; tmr_val = 16'h0000;
        step();
        tmr_val = 16'h1234;
        step();
        chk("R9 mode 1100 idle", outs(), 4'b1000);
    endtask

    task automatic t_bytes();
        mode = 4'b1010; cmp_val = 16'hABCD; tmr_val = 16'h0000;
        step();
        tmr_val = 16'hAB00;
        step();
        chk("R10 high byte only", outs(), 4'b1000);
        tmr_val = 16'h00CD;
        step();
        chk("R10 low byte only", outs(), 4'b1000);
        tmr_val = 16'hABCD;
        step();
        chk("R10 full match", outs(), 4'b1100);
    endtask

    initial begin
        t_reset();
        t_set();
        t_flag();
        t_reentry();
        t_refire();
        t_sev();
        t_other();
        t_bytes();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule